// File: doc/BRIEF.md
# Power Area Shutoff and Resume Sequencer

This block sequences the switching of a set of power areas between the on and off states on behalf of software. The areas are split into channel groups, each of which holds a fixed number of area bits. Software asks for a transition by writing a single area bit to the shutoff or resume control register of that area's channel. The sequencer then holds the area in transition for a programmable settle time. When the time is up it updates the power state of the area and, if the area's enable bit allows it, records a completion bit.

Only one transition runs at a time. While it runs, both ready flags in the status register read zero. A request that arrives in this window is not queued: the sequencer sets the area's error bit and discards the request, and software reissues it later. Completion bits are cleared by writing ones to a clear register. A mask register keeps completions out of the interrupt line but does not stop them being recorded. The block also holds an external-request mask word, which it drives out unchanged.

Top module: `pdc_top`

## Requirements
- R1: After reset every area is powered on. The status register reads 0x3. The completion, enable, mask, error and external-mask registers read zero, the settle register holds SETTLE_RST, and `irq_o` is low.
- R2: Common registers sit at these byte addresses: status 0x00, completion status 0x04, completion clear 0x08, enable 0x0C, mask 0x10, external mask 0x20, settle count 0x24. Channel c starts at 0x40 + 0x20*c, with these offsets: power state +0x00, shutoff control +0x04, shutoff in progress +0x08, resume control +0x0C, resume in progress +0x10, error +0x14. Control and clear registers read as zero.
- R3: A request is a write to a control register whose data has exactly one bit set, and that bit must lie in bits [AREAS_PER_CH-1:0]. Bit i of channel c names area c*AREAS_PER_CH+i. Any other write data to a control register is ignored.
- R4: After an accepted request, status bit 0 (shutoff ready) and bit 1 (resume ready) both read zero for exactly SETTLE+1 cycles counted from the write edge. SETTLE is the settle count held when the request was accepted. During those cycles the area's bit reads one in the shutoff-in-progress or resume-in-progress register.
- R5: When a transition completes, the area's power state bit reads 1 after a shutoff and 0 after a resume.
- R6: A request that arrives while a transition is running sets the error bit of the requested area and has no other effect. The running transition and the power states carry on unchanged.
- R7: An area's error bit clears when a later request to that area is accepted.
- R8: A completion sets bit (area index) of the completion status register only if that area's enable bit is set. The mask bit has no effect on this recording.
- R9: Writing ones to the clear register clears those completion bits. If a completion and a clear of the same bit fall in the same cycle, the bit ends up set.
- R10: `irq_o` is high exactly when some completion bit is set whose mask bit is clear.
- R11: `ext_mask_o` presents the value last written to the external mask register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address for reads and writes |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | 1 | Completion interrupt |
| ext_mask_o | output | 32 | External-request mask word |

## Verification
Two things can land on the same clock edge. A transition can finish at the moment software writes the clear register for the same area's completion bit. A new request can also arrive on the very edge where the running transition retires. The bench reads the reference model's countdown at each falling edge. It times the clear write, and separately a second request, so that the write lands on the retiring edge. It then expects the completion bit to stay set, and expects the late request to be refused with its error bit raised. The model's interrupt line is also compared against `irq_o` on every cycle, so a wrong merge shows up at once.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

    // common register byte addresses
    localparam int unsigned A_STATUS = 'h00;
    localparam int unsigned A_DONE   = 'h04;
    localparam int unsigned A_CLEAR  = 'h08;
    localparam int unsigned A_ENABLE = 'h0C;
    localparam int unsigned A_MASK   = 'h10;
    localparam int unsigned A_XMASK  = 'h20;
    localparam int unsigned A_SETTLE = 'h24;

    // channel groups
    localparam int unsigned CH_BASE   = 'h40;
    localparam int unsigned CH_SHIFT  = 5;
    localparam int unsigned O_PWR     = 'h00;
    localparam int unsigned O_OFF_REQ = 'h04;
    localparam int unsigned O_OFF_RUN = 'h08;
    localparam int unsigned O_ON_REQ  = 'h0C;
    localparam int unsigned O_ON_RUN  = 'h10;
    localparam int unsigned O_ERR     = 'h14;

    typedef enum logic {
        DIR_ON  = 1'b0,
        DIR_OFF = 1'b1
    } dir_e;

endpackage

// File: rtl/pdc_seq.sv
module pdc_seq
    import pdc_pkg::*;
#(
    parameter int unsigned AREA_W   = 3,
    parameter int unsigned SETTLE_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid_i,
    input  logic [AREA_W-1:0]   req_area_i,
    input  dir_e                req_dir_i,
    input  logic [SETTLE_W-1:0] settle_i,
    output logic                busy_o,
    output logic                accept_o,
    output logic                reject_o,
    output logic                done_o,
    output logic [AREA_W-1:0]   cur_area_o,
    output dir_e                cur_dir_o
);

    typedef struct packed {
        logic                busy;
        logic [SETTLE_W-1:0] cnt;
        logic [AREA_W-1:0]   area;
        dir_e                dir;
    } seq_t;

    seq_t s_d, s_q;

    assign busy_o     = s_q.busy;
    assign accept_o   = req_valid_i && !s_q.busy;
    assign reject_o   = req_valid_i && s_q.busy;
    assign done_o     = s_q.busy && (s_q.cnt == '0);
    assign cur_area_o = s_q.area;
    assign cur_dir_o  = s_q.dir;

    always_comb begin
        s_d = s_q;
        if (accept_o) begin
            s_d.busy = 1'b1;
            s_d.cnt  = settle_i;
            s_d.area = req_area_i;
            s_d.dir  = req_dir_i;
        end else if (s_q.busy) begin
            if (s_q.cnt == '0) begin
                s_d.busy = 1'b0;
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{busy: 1'b0, cnt: '0, area: '0, dir: DIR_ON};
        end else begin
            s_q <= s_d;
        end
    end

    // R6: a refused request leaves the running transition alone
    assert_inflight_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && !done_o) |=> (busy_o && $stable(cur_area_o) && $stable(cur_dir_o)));

    // R4: an accepted request loads the settle count it was given
    assert_settle_loaded_R4: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |=> (busy_o && s_q.cnt == $past(settle_i)));

    // R4: the retiring edge frees the sequencer
    assert_retire_frees_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);

endmodule

// File: rtl/pdc_area_bank.sv
module pdc_area_bank
    import pdc_pkg::*;
#(
    parameter int unsigned NUM_AREAS = 8,
    parameter int unsigned AREA_W    = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 accept_i,
    input  logic                 reject_i,
    input  logic [AREA_W-1:0]    req_area_i,
    input  logic                 busy_i,
    input  logic                 done_i,
    input  logic [AREA_W-1:0]    cur_area_i,
    input  dir_e                 cur_dir_i,
    output logic [NUM_AREAS-1:0] pwr_off_o,
    output logic [NUM_AREAS-1:0] err_o,
    output logic [NUM_AREAS-1:0] off_run_o,
    output logic [NUM_AREAS-1:0] on_run_o
);

    typedef struct packed {
        logic [NUM_AREAS-1:0] pwr_off;
        logic [NUM_AREAS-1:0] err;
    } bank_t;

    bank_t b_d, b_q;
    logic [NUM_AREAS-1:0] pwr_nx, err_nx, cur_sel;

    for (genvar a = 0; a < NUM_AREAS; a++) begin : g_area
        logic hit_cur, hit_req;
        assign hit_cur   = (cur_area_i == AREA_W'(a));
        assign hit_req   = (req_area_i == AREA_W'(a));
        assign cur_sel[a] = busy_i && hit_cur;
        assign pwr_nx[a] = (done_i && hit_cur) ? (cur_dir_i == DIR_OFF) : b_q.pwr_off[a];
        assign err_nx[a] = (reject_i && hit_req) ? 1'b1 :
                           (accept_i && hit_req) ? 1'b0 : b_q.err[a];
    end

    always_comb begin
        b_d         = b_q;
        b_d.pwr_off = pwr_nx;
        b_d.err     = err_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_q <= '0;
        end else begin
            b_q <= b_d;
        end
    end

    assign pwr_off_o = b_q.pwr_off;
    assign err_o     = b_q.err;
    assign off_run_o = (cur_dir_i == DIR_OFF) ? cur_sel : '0;
    assign on_run_o  = (cur_dir_i == DIR_ON)  ? cur_sel : '0;

    // R6: a refused request on a non-retiring edge moves no power state
    assert_refused_keeps_power_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reject_i && !done_i) |=> $stable(pwr_off_o));

    // R7: acceptance clears the area's error flag
    assert_accept_clears_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        accept_i |=> ((err_o & (NUM_AREAS'(1) << $past(req_area_i))) == '0));

    // R4: at most one area is ever in transition
    assert_single_transition_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(off_run_o | on_run_o));

endmodule

// File: rtl/pdc_irq.sv
module pdc_irq #(
    parameter int unsigned NUM_AREAS = 8,
    parameter int unsigned AREA_W    = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_AREAS-1:0] wdata_i,
    input  logic                 clr_we_i,
    input  logic                 en_we_i,
    input  logic                 msk_we_i,
    input  logic                 done_i,
    input  logic [AREA_W-1:0]    cur_area_i,
    output logic [NUM_AREAS-1:0] stat_o,
    output logic [NUM_AREAS-1:0] en_o,
    output logic [NUM_AREAS-1:0] msk_o,
    output logic                 irq_o
);

    typedef struct packed {
        logic [NUM_AREAS-1:0] stat;
        logic [NUM_AREAS-1:0] en;
        logic [NUM_AREAS-1:0] msk;
    } irq_t;

    irq_t r_d, r_q;
    logic [NUM_AREAS-1:0] set_v, clr_v;

    always_comb begin
        r_d   = r_q;
        set_v = '0;
        clr_v = clr_we_i ? wdata_i : '0;
        if (done_i && r_q.en[cur_area_i]) begin
            set_v = NUM_AREAS'(1) << cur_area_i;
        end
        r_d.stat = (r_q.stat & ~clr_v) | set_v;
        if (en_we_i) begin
            r_d.en = wdata_i;
        end
        if (msk_we_i) begin
            r_d.msk = wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign stat_o = r_q.stat;
    assign en_o   = r_q.en;
    assign msk_o  = r_q.msk;
    assign irq_o  = |(r_q.stat & ~r_q.msk);

    // R8: no status bit appears for a disabled area
    assert_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_o & ~$past(stat_o) & ~$past(en_o)) == '0));

    // R9: a clear with no completion alongside empties the chosen bits
    assert_clear_works_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we_i && !done_i) |=> ((stat_o & $past(wdata_i)) == '0));

    // R9: an enabled completion survives a same-cycle clear
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && en_o[cur_area_i]) |=> ((stat_o & (NUM_AREAS'(1) << $past(cur_area_i))) != '0));

endmodule

// File: rtl/pdc_top.sv
module pdc_top
    import pdc_pkg::*;
#(
    parameter int unsigned NUM_CH       = 2,
    parameter int unsigned AREAS_PER_CH = 4,
    parameter int unsigned ADDR_W       = 12,
    parameter int unsigned SETTLE_W     = 16,
    parameter int unsigned SETTLE_RST   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_o,
    output logic [31:0]       ext_mask_o
);

    localparam int unsigned NUM_AREAS = NUM_CH * AREAS_PER_CH;
    localparam int unsigned AREA_W    = (NUM_AREAS > 1) ? $clog2(NUM_AREAS) : 1;
    localparam int unsigned LANE_W    = (AREAS_PER_CH > 1) ? $clog2(AREAS_PER_CH) : 1;
    localparam int unsigned CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int unsigned SEL_W     = ADDR_W - CH_SHIFT;

    typedef struct packed {
        logic [31:0]         xmask;
        logic [SETTLE_W-1:0] settle;
    } cfg_t;

    cfg_t c_d, c_q;

    // address decode
    logic [ADDR_W-1:0]       rel;
    logic [SEL_W-1:0]        ch_sel;
    logic [CH_SHIFT-1:0]     ch_off;
    logic [CH_W-1:0]         ch_idx;
    logic                    in_ch;
    logic [AREAS_PER_CH-1:0] lane;
    logic [LANE_W-1:0]       lane_idx;
    logic                    lane_ok;
    logic                    req_valid;
    dir_e                    req_dir;
    logic [AREA_W-1:0]       req_area;

    always_comb begin
        rel      = bus_addr - ADDR_W'(CH_BASE);
        ch_sel   = rel[ADDR_W-1:CH_SHIFT];
        ch_off   = rel[CH_SHIFT-1:0];
        ch_idx   = ch_sel[CH_W-1:0];
        in_ch    = (bus_addr >= ADDR_W'(CH_BASE)) && (ch_sel < SEL_W'(NUM_CH));
        lane     = bus_wdata[AREAS_PER_CH-1:0];
        lane_ok  = $onehot(lane) && ((bus_wdata >> AREAS_PER_CH) == '0);
        lane_idx = '0;
        for (int i = 0; i < AREAS_PER_CH; i++) begin
            if (lane[i]) lane_idx = LANE_W'(i);
        end
        req_dir   = (ch_off == CH_SHIFT'(O_OFF_REQ)) ? DIR_OFF : DIR_ON;
        req_valid = bus_we && in_ch && lane_ok &&
                    ((ch_off == CH_SHIFT'(O_OFF_REQ)) || (ch_off == CH_SHIFT'(O_ON_REQ)));
        req_area  = AREA_W'(AREA_W'(ch_idx) * AREA_W'(AREAS_PER_CH) + AREA_W'(lane_idx));
    end

    // configuration registers
    always_comb begin
        c_d = c_q;
        if (bus_we && bus_addr == ADDR_W'(A_XMASK))  c_d.xmask  = bus_wdata;
        if (bus_we && bus_addr == ADDR_W'(A_SETTLE)) c_d.settle = bus_wdata[SETTLE_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '{xmask: '0, settle: SETTLE_W'(SETTLE_RST)};
        end else begin
            c_q <= c_d;
        end
    end

    assign ext_mask_o = c_q.xmask;

    // sequencer, area state, completion logic
    logic              busy, accept, reject, done;
    logic [AREA_W-1:0] cur_area;
    dir_e              cur_dir;
    logic [NUM_AREAS-1:0] pwr_off, err, off_run, on_run, stat, en, msk;

    pdc_seq #(.AREA_W(AREA_W), .SETTLE_W(SETTLE_W)) u_seq (
        .clk, .rst_n,
        .req_valid_i (req_valid),
        .req_area_i  (req_area),
        .req_dir_i   (req_dir),
        .settle_i    (c_q.settle),
        .busy_o      (busy),
        .accept_o    (accept),
        .reject_o    (reject),
        .done_o      (done),
        .cur_area_o  (cur_area),
        .cur_dir_o   (cur_dir)
    );

    pdc_area_bank #(.NUM_AREAS(NUM_AREAS), .AREA_W(AREA_W)) u_bank (
        .clk, .rst_n,
        .accept_i   (accept),
        .reject_i   (reject),
        .req_area_i (req_area),
        .busy_i     (busy),
        .done_i     (done),
        .cur_area_i (cur_area),
        .cur_dir_i  (cur_dir),
        .pwr_off_o  (pwr_off),
        .err_o      (err),
        .off_run_o  (off_run),
        .on_run_o   (on_run)
    );

    pdc_irq #(.NUM_AREAS(NUM_AREAS), .AREA_W(AREA_W)) u_irq (
        .clk, .rst_n,
        .wdata_i    (bus_wdata[NUM_AREAS-1:0]),
        .clr_we_i   (bus_we && bus_addr == ADDR_W'(A_CLEAR)),
        .en_we_i    (bus_we && bus_addr == ADDR_W'(A_ENABLE)),
        .msk_we_i   (bus_we && bus_addr == ADDR_W'(A_MASK)),
        .done_i     (done),
        .cur_area_i (cur_area),
        .stat_o     (stat),
        .en_o       (en),
        .msk_o      (msk),
        .irq_o      (irq_o)
    );

    // per-channel views of the area vectors
    logic [AREAS_PER_CH-1:0] v_pwr [NUM_CH];
    logic [AREAS_PER_CH-1:0] v_err [NUM_CH];
    logic [AREAS_PER_CH-1:0] v_off [NUM_CH];
    logic [AREAS_PER_CH-1:0] v_on  [NUM_CH];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign v_pwr[c] = pwr_off[c*AREAS_PER_CH +: AREAS_PER_CH];
        assign v_err[c] = err[c*AREAS_PER_CH +: AREAS_PER_CH];
        assign v_off[c] = off_run[c*AREAS_PER_CH +: AREAS_PER_CH];
        assign v_on[c]  = on_run[c*AREAS_PER_CH +: AREAS_PER_CH];
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (in_ch) begin
            unique case (ch_off)
                CH_SHIFT'(O_PWR):     bus_rdata = 32'(v_pwr[ch_idx]);
                CH_SHIFT'(O_OFF_RUN): bus_rdata = 32'(v_off[ch_idx]);
                CH_SHIFT'(O_ON_RUN):  bus_rdata = 32'(v_on[ch_idx]);
                CH_SHIFT'(O_ERR):     bus_rdata = 32'(v_err[ch_idx]);
                default:              bus_rdata = '0;
            endcase
        end else begin
            unique case (bus_addr)
                ADDR_W'(A_STATUS): bus_rdata = {30'b0, !busy, !busy};
                ADDR_W'(A_DONE):   bus_rdata = 32'(stat);
                ADDR_W'(A_ENABLE): bus_rdata = 32'(en);
                ADDR_W'(A_MASK):   bus_rdata = 32'(msk);
                ADDR_W'(A_XMASK):  bus_rdata = c_q.xmask;
                ADDR_W'(A_SETTLE): bus_rdata = 32'(c_q.settle);
                default:           bus_rdata = '0;
            endcase
        end
    end

    // R11: the mask word follows a write one cycle later
    assert_xmask_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(A_XMASK)) |=> (ext_mask_o == $past(bus_wdata)));

    // R3: a malformed control write starts nothing
    assert_bad_data_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && in_ch && !lane_ok && !busy) |=> !busy);

endmodule

// File: tb/pdc_top_tb_top.sv
`timescale 1ns/1ps
module pdc_top_tb_top;

    localparam int NCH = 2;
    localparam int APC = 4;
    localparam int NA  = NCH * APC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;
    logic [31:0] ext_mask_o;

    always #2 clk = ~clk;

    pdc_top #(.NUM_CH(NCH), .AREAS_PER_CH(APC), .ADDR_W(12), .SETTLE_W(16), .SETTLE_RST(4)) dut_i (
        .clk, .rst_n, .bus_addr, .bus_we, .bus_wdata, .bus_rdata, .irq_o, .ext_mask_o
    );

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    // ---------------- reference model ----------------
    bit          m_busy;
    int          m_cnt, m_area;
    bit          m_off;
    bit [NA-1:0] m_pwr, m_err, m_isr, m_ier, m_imr;
    bit [31:0]   m_xm;
    int          m_settle;

    function automatic int req_area_of(input logic [11:0] a, input logic [31:0] d, output bit off);
        int ch, of, lanes;
        off = 0;
        if (a < 12'h40) return -1;
        ch = (int'(a) - 'h40) / 32;
        of = (int'(a) - 'h40) % 32;
        if (ch >= NCH) return -1;
        if (of != 'h04 && of != 'h0C) return -1;
        if (d >= (32'd1 << APC) || $countones(d) != 1) return -1;
        off = (of == 'h04);
        lanes = 0;
        while (d[lanes] == 1'b0) lanes++;
        return ch * APC + lanes;
    endfunction

    always @(posedge clk) begin : model
        bit was_busy, fin, off;
        int tgt;
        if (!rst_n) begin
            m_busy = 0; m_cnt = 0; m_area = 0; m_off = 0;
            m_pwr = '0; m_err = '0; m_isr = '0; m_ier = '0; m_imr = '0;
            m_xm = '0; m_settle = 4;
        end else begin
            was_busy = m_busy;
            fin = m_busy && (m_cnt == 0);
            tgt = bus_we ? req_area_of(bus_addr, bus_wdata, off) : -1;
            if (bus_we && bus_addr == 12'h08) m_isr &= ~bus_wdata[NA-1:0];
            if (fin) begin
                m_pwr[m_area] = m_off;
                if (m_ier[m_area]) m_isr[m_area] = 1'b1;
                m_busy = 0;
            end else if (m_busy) begin
                m_cnt--;
            end
            if (tgt >= 0) begin
                if (was_busy) m_err[tgt] = 1'b1;
                else begin
                    m_err[tgt] = 1'b0;
                    m_busy = 1; m_cnt = m_settle; m_area = tgt; m_off = off;
                end
            end
            if (bus_we && bus_addr == 12'h0C) m_ier = bus_wdata[NA-1:0];
            if (bus_we && bus_addr == 12'h10) m_imr = bus_wdata[NA-1:0];
            if (bus_we && bus_addr == 12'h20) m_xm = bus_wdata;
            if (bus_we && bus_addr == 12'h24) m_settle = int'(bus_wdata[15:0]);
        end
    end

    function automatic logic [31:0] exp_read(input logic [11:0] a);
        int ch, of;
        bit [NA-1:0] run;
        run = '0;
        if (m_busy) run[m_area] = 1'b1;
        if (a >= 12'h40 && (int'(a) - 'h40) / 32 < NCH) begin
            ch = (int'(a) - 'h40) / 32;
            of = (int'(a) - 'h40) % 32;
            case (of)
                'h00: return 32'((m_pwr >> (ch*APC)) & 4'hF);
                'h08: return m_off  ? 32'((run >> (ch*APC)) & 4'hF) : 32'h0;
                'h10: return !m_off ? 32'((run >> (ch*APC)) & 4'hF) : 32'h0;
                'h14: return 32'((m_err >> (ch*APC)) & 4'hF);
                default: return 32'h0;
            endcase
        end
        case (a)
            12'h00: return m_busy ? 32'h0 : 32'h3;
            12'h04: return 32'(m_isr);
            12'h0C: return 32'(m_ier);
            12'h10: return 32'(m_imr);
            12'h20: return m_xm;
            12'h24: return 32'(m_settle);
            default: return 32'h0;
        endcase
    endfunction

    // ---------------- helpers ----------------
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    // read against a fixed value and against the model
    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
        chk({tag, " model"}, bus_rdata, exp_read(a));
    endtask

    task automatic wait_idle();
        while (m_busy) @(negedge clk);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    // R10 / R11: per-cycle comparison of the outputs
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R10 irq_o", 32'(irq_o), 32'(|(m_isr & ~m_imr)));
            chk("R11 ext_mask_o", ext_mask_o, m_xm);
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog act=running exp=finished");
        summary();
    end

    // ---------------- stimulus ----------------
    initial begin
        int lowc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(12'h000, 32'h3, "R1 status");
        rd(12'h040, 32'h0, "R1 power ch0");
        rd(12'h060, 32'h0, "R1 power ch1");
        rd(12'h004, 32'h0, "R1 completion");
        rd(12'h074, 32'h0, "R1 error ch1");
        rd(12'h024, 32'h4, "R1 settle reset");
        chk("R1 irq low", 32'(irq_o), 32'h0);

        // R2 / R11 configuration registers
        wr(12'h024, 32'd3);
        wr(12'h020, 32'hA5A5_0F0F);
        rd(12'h024, 32'h3, "R2 settle readback");
        rd(12'h020, 32'hA5A5_0F0F, "R2 xmask readback");
        chk("R11 ext_mask_o", ext_mask_o, 32'hA5A5_0F0F);
        wr(12'h00C, 32'h0000_00EF);    // area 4 disabled
        rd(12'h00C, 32'hEF, "R2 enable readback");

        // R3 malformed requests are ignored
        wr(12'h044, 32'h3);
        rd(12'h000, 32'h3, "R3 two bits ignored");
        wr(12'h044, 32'h10);
        rd(12'h000, 32'h3, "R3 out-of-lane bit ignored");

        // R4 shutoff of area 1 (ch0 bit1), ready low for SETTLE+1 cycles
        wr(12'h044, 32'h2);
        rd(12'h048, 32'h2, "R4 shutoff in progress");
        rd(12'h050, 32'h0, "R4 no resume in progress");

        // R6 request while busy: area 4 (ch1 bit0) gets an error
        wr(12'h06C, 32'h1);
        rd(12'h074, 32'h1, "R6 error flagged");
        rd(12'h048, 32'h2, "R6 transition kept");
        wait_idle();
        rd(12'h040, 32'h2, "R5 area1 off");
        rd(12'h060, 32'h0, "R6 ch1 power untouched");
        rd(12'h004, 32'h2, "R8 completion recorded");
        chk("R10 irq high", 32'(irq_o), 32'h1);

        // R4 exact window length, separate run
        wr(12'h04C, 32'h2);           // resume area 1
        lowc = 0;
        for (int k = 0; k < 50; k++) begin
            bus_addr = 12'h000; #1;
            if (bus_rdata[1:0] == 2'b00) lowc++;
            else break;
            @(negedge clk);
        end
        chk("R4 ready low cycles", 32'(lowc), 32'd4);
        rd(12'h040, 32'h0, "R5 area1 back on");

        // R8 mask keeps recording, R10 mask drops irq
        wr(12'h010, 32'h2);
        chk("R10 masked irq", 32'(irq_o), 32'h0);
        rd(12'h004, 32'h2, "R8 status kept under mask");
        wr(12'h010, 32'h0);
        wr(12'h008, 32'h2);
        rd(12'h004, 32'h0, "R9 plain clear");

        // R7 later accepted request clears error; R8 area 4 disabled
        wr(12'h064, 32'h1);           // shutoff area 4
        rd(12'h074, 32'h0, "R7 error cleared");
        wait_idle();
        rd(12'h060, 32'h1, "R5 area4 off");
        rd(12'h004, 32'h0, "R8 disabled area not recorded");

        // R9 clear lands on the completing edge of area 1 (bit still set after)
        wr(12'h044, 32'h2);
        wait_idle();
        rd(12'h004, 32'h2, "R9 precondition set");
        wr(12'h04C, 32'h2);
        while (!(m_busy && m_cnt == 0)) @(negedge clk);
        bus_we = 1'b1; bus_addr = 12'h008; bus_wdata = 32'h2;
        @(negedge clk);
        bus_we = 1'b0;
        rd(12'h004, 32'h2, "R9 set wins over clear");
        rd(12'h040, 32'h0, "R5 area1 on again");

        // R6 request on the retiring edge is still refused
        wr(12'h008, 32'h2);
        wr(12'h044, 32'h1);           // shutoff area 0
        while (!(m_busy && m_cnt == 0)) @(negedge clk);
        bus_we = 1'b1; bus_addr = 12'h064; bus_wdata = 32'h2;   // area 5
        @(negedge clk);
        bus_we = 1'b0;
        rd(12'h074, 32'h2, "R6 refused on retire edge");
        rd(12'h000, 32'h3, "R6 nothing started");
        rd(12'h040, 32'h1, "R5 area0 off");

        // R4 zero settle: one cycle window
        wr(12'h024, 32'h0);
        wr(12'h06C, 32'h1);           // resume area 4
        rd(12'h070, 32'h1, "R4 resume in progress");
        @(negedge clk);
        rd(12'h000, 32'h3, "R4 zero settle done");
        rd(12'h060, 32'h0, "R5 area4 on");

        repeat (2) @(negedge clk);
        summary();
    end

endmodule